// File: doc/BRIEF.md
# Headset Jack Detect Status and Interrupt Controller

This block turns three comparator outputs into debounced status bits, sticky change flags and one interrupt line. The three comparators watch the jack-sense pin, the left headphone pin and a check of the jack-sense voltage against the microphone bias. Software reaches the block through a small register port. It reads the status, and that read clears the flags. It also writes the interrupt enables, the sleep-detect enable and the debounce length.

The block has two detection modes, chosen by the power state.

- **Sleep mode:** this mode applies while the device is shut down with supply present and sleep detect enabled. An unloaded pin reads high. Plugging in a jack pulls the jack-sense pin, the left headphone pin or both low. Any debounced change on either pin sets the jack flag.
- **Powered mode:** this mode applies while the device is powered and the microphone interface is on. The mic level reads high when the jack-sense voltage has risen to the bias level, which means the headset was removed. It reads low when that voltage drops below the bias threshold, which means a headset was inserted. Either change sets the mic flag.

Each comparator input passes through a two-flop synchronizer and then a debounce counter whose length software can set.

Top module: `jack_detect_irq`

## Requirements
- R1: Within four clock cycles after reset is released, the status levels equal the input levels. No sticky flag is set and `irq` is low.
- R2: A change on a comparator input reaches its status level exactly L+3 clock edges after it is applied, where L is the debounce length. An excursion lasting L or fewer samples changes nothing.
- R3: Register address 2 holds the 8-bit debounce length L. It is writable and reads back, and its value after reset is 4.
- R4: Status bit 4 is the jack flag. It sets on a debounced change of the jack-sense level (status bit 0) or the left headphone level (status bit 1). It sets only while `shutdown`, `supply_ok` and the sleep enable (control bit 2) are all high.
- R5: Status bit 2 is the mic level, where 1 means removed and 0 means inserted. Status bit 5 is the mic flag. It sets on a debounced mic change only while `shutdown` is low and `mic_if_en` is high.
- R6: `irq` is high exactly when (bit 4 and control bit 0) or (bit 5 and control bit 1) holds.
- R7: Reading address 0 returns the status on `reg_rdata` on the next cycle and clears both flags. A flag event that lands on the same edge as the read leaves its flag set.
- R8: Address 1 reads back control bits 2:0, with the upper bits zero. Any unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Device is shut down |
| supply_ok | input | 1 | Supply is present |
| mic_if_en | input | 1 | Microphone interface is enabled |
| js_raw | input | 1 | Jack-sense comparator, high when unloaded |
| hpl_raw | input | 1 | Left headphone comparator, high when unloaded |
| mic_raw | input | 1 | Mic-bias comparator, high when removed |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt, active high |

## Verification
The hardest case to reach is a read of the status landing on the same edge as a debounced change that sets a flag. The bench applies the input change, counts exactly L+2 cycles, and then raises the read strobe so that the read and the flag event fall on one edge. It then checks two things: the returned byte must show the flag clear, and `irq` must stay high afterwards. The exact L+3 latency and a pulse one sample too short are also reached only by careful cycle counting on `irq`.

// File: rtl/jdi_pkg.sv
package jdi_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int NCH    = 3;
  localparam int CH_JS  = 0;
  localparam int CH_HPL = 1;
  localparam int CH_MIC = 2;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DEB    = 2'd2;

  typedef struct packed {
    logic sleep_en;
    logic ien_mic;
    logic ien_jack;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] pack_status(input logic [NCH-1:0] lvl,
                                                    input logic jack_flag,
                                                    input logic mic_flag);
    logic [DATA_W-1:0] w;
    w = '0;
    w[NCH-1:0] = lvl;
    w[4] = jack_flag;
    w[5] = mic_flag;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
    return DATA_W'(c);
  endfunction
endpackage

// File: rtl/jdi_sync.sv
module jdi_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/jdi_debounce.sv
module jdi_debounce #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prime,
  input  logic             run,
  input  logic             sin,
  input  logic [CNT_W-1:0] len,
  output logic             level,
  output logic             ev
);
  logic [CNT_W-1:0] cnt;
  logic             mismatch;
  logic             done;

  function automatic logic reached(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] l);
    return c == l;
  endfunction

  assign mismatch = sin != level;
  assign done     = reached(cnt, len);
  assign ev       = run && mismatch && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (prime) begin
      level <= sin;
      cnt   <= '0;
    end else if (run) begin
      if (mismatch) begin
        if (done) begin
          level <= sin;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/jdi_regs.sv
module jdi_regs
  import jdi_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DEB_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NCH-1:0]    lvl,
  input  logic              jack_set,
  input  logic              mic_set,
  output logic [DATA_W-1:0] reg_rdata,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  deb_len,
  output logic              sticky_jack,
  output logic              sticky_mic,
  output logic              rd_stat_hit
);
  assign rd_stat_hit = reg_rd && (reg_addr == ADDR_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      deb_len <= CNT_W'(DEB_RESET);
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CTRL) ctrl    <= ctrl_t'(reg_wdata[2:0]);
      if (reg_addr == ADDR_DEB)  deb_len <= reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_jack <= 1'b0;
      sticky_mic  <= 1'b0;
    end else begin
      if (jack_set)         sticky_jack <= 1'b1;
      else if (rd_stat_hit) sticky_jack <= 1'b0;
      if (mic_set)          sticky_mic  <= 1'b1;
      else if (rd_stat_hit) sticky_mic  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADDR_STATUS: reg_rdata <= pack_status(lvl, sticky_jack, sticky_mic);
        ADDR_CTRL:   reg_rdata <= pack_ctrl(ctrl);
        ADDR_DEB:    reg_rdata <= DATA_W'(deb_len);
        default:     reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/jack_detect_irq.sv
module jack_detect_irq
  import jdi_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DEB_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shutdown,
  input  logic              supply_ok,
  input  logic              mic_if_en,
  input  logic              js_raw,
  input  logic              hpl_raw,
  input  logic              mic_raw,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int INIT_CYC = 2;

  logic [NCH-1:0] raw_vec, sync_vec, lvl, ev_vec;
  logic [1:0]     init_cnt;
  logic           primed, prime;
  logic           sleep_act, mic_act, jack_set, mic_set;
  logic           sticky_jack, sticky_mic, rd_stat_hit;
  logic           ien_jack, ien_mic;
  ctrl_t          ctrl;
  logic [CNT_W-1:0] deb_len;

  assign raw_vec = {mic_raw, hpl_raw, js_raw};

  jdi_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(sync_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt <= '0;
      primed   <= 1'b0;
    end else begin
      if (init_cnt != 2'(INIT_CYC)) init_cnt <= init_cnt + 1'b1;
      if (prime) primed <= 1'b1;
    end
  end
  assign prime = !primed && (init_cnt == 2'(INIT_CYC));

  for (genvar c = 0; c < NCH; c++) begin : g_deb
    jdi_debounce #(.CNT_W(CNT_W)) u_deb (
      .clk(clk), .rst_n(rst_n), .prime(prime), .run(primed),
      .sin(sync_vec[c]), .len(deb_len), .level(lvl[c]), .ev(ev_vec[c])
    );
  end

  assign sleep_act = shutdown && supply_ok && ctrl.sleep_en;
  assign mic_act   = !shutdown && mic_if_en;
  assign jack_set  = sleep_act && (ev_vec[CH_JS] || ev_vec[CH_HPL]);
  assign mic_set   = mic_act && ev_vec[CH_MIC];

  jdi_regs #(.CNT_W(CNT_W), .DEB_RESET(DEB_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .lvl(lvl),
    .jack_set(jack_set), .mic_set(mic_set), .reg_rdata(reg_rdata),
    .ctrl(ctrl), .deb_len(deb_len), .sticky_jack(sticky_jack),
    .sticky_mic(sticky_mic), .rd_stat_hit(rd_stat_hit)
  );

  assign ien_jack = ctrl.ien_jack;
  assign ien_mic  = ctrl.ien_mic;
  assign irq = (sticky_jack && ien_jack) || (sticky_mic && ien_mic);
endmodule

// File: rtl/jack_detect_irq_chk.sv
module jack_detect_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       reg_wr,
  input logic       primed,
  input logic       sleep_act,
  input logic       mic_act,
  input logic       jack_set,
  input logic       rd_stat_hit,
  input logic       sticky_jack,
  input logic       sticky_mic,
  input logic [2:0] lvl,
  input logic [2:0] ev_vec
);
  AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !(sticky_jack || sticky_mic)); // R1
  AST_LVL_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(primed) && lvl != $past(lvl)) |-> $past(|ev_vec)); // R2
  AST_JACK_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_jack) |-> $past(sleep_act)); // R4
  AST_MIC_WHEN_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_mic) |-> $past(mic_act)); // R5
  AST_IRQ_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rd_stat_hit || reg_wr)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_hit && !jack_set) |=> !sticky_jack); // R7
endmodule

bind jack_detect_irq jack_detect_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .reg_wr(reg_wr), .primed(primed),
  .sleep_act(sleep_act), .mic_act(mic_act), .jack_set(jack_set),
  .rd_stat_hit(rd_stat_hit), .sticky_jack(sticky_jack),
  .sticky_mic(sticky_mic), .lvl(lvl), .ev_vec(ev_vec)
);

// File: tb/jack_detect_irq_bench.sv
module jack_detect_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shutdown = 1'b0, supply_ok = 1'b1, mic_if_en = 1'b0;
  logic js_raw = 1'b1, hpl_raw = 1'b1, mic_raw = 1'b1;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jack_detect_irq u_jack_detect_irq (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .supply_ok(supply_ok),
    .mic_if_en(mic_if_en), .js_raw(js_raw), .hpl_raw(hpl_raw), .mic_raw(mic_raw),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic       sd, sup, mif;
    logic [2:0] ctrl;
    logic       js, hpl, mic;
    logic [7:0] st;
    logic       irq;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b1, 1'b0, 3'b101, 1'b0, 1'b1, 1'b1, 8'h16, 1'b1},
    '{1'b1, 1'b1, 1'b0, 3'b101, 1'b0, 1'b0, 1'b1, 8'h14, 1'b1},
    '{1'b1, 1'b1, 1'b0, 3'b001, 1'b1, 1'b0, 1'b1, 8'h05, 1'b0},
    '{1'b0, 1'b1, 1'b1, 3'b010, 1'b1, 1'b0, 1'b0, 8'h21, 1'b1},
    '{1'b0, 1'b1, 1'b0, 3'b010, 1'b1, 1'b0, 1'b1, 8'h05, 1'b0},
    '{1'b0, 1'b1, 1'b1, 3'b000, 1'b1, 1'b0, 1'b0, 8'h21, 1'b0},
    '{1'b1, 1'b0, 1'b0, 3'b101, 1'b1, 1'b1, 1'b0, 8'h03, 1'b0},
    '{1'b0, 1'b1, 1'b1, 3'b111, 1'b0, 1'b1, 1'b0, 8'h02, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    step(1);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    step(2);
    rst_n = 1'b1;
    step(6);
    // R1: reset state follows inputs, no flags
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    rd(2'd0, d); check("R1 status after reset", d, 8'h07);
    rd(2'd2, d); check("R3 debounce reset value", d, 8'h04);

    // table walk: R4 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, {5'd0, VEC[i].ctrl});
      shutdown = VEC[i].sd; supply_ok = VEC[i].sup; mic_if_en = VEC[i].mif;
      js_raw = VEC[i].js; hpl_raw = VEC[i].hpl; mic_raw = VEC[i].mic;
      step(10);
      check($sformatf("R6 irq vector %0d", i), {7'd0, irq}, {7'd0, VEC[i].irq});
      rd(2'd0, d);
      check($sformatf("R4/R5 status vector %0d", i), d, VEC[i].st);
    end

    // R3: debounce length write/readback
    wr(2'd2, 8'd2);
    rd(2'd2, d); check("R3 debounce readback", d, 8'h02);

    // R2: exact latency L+3 with L=2, observed on irq
    shutdown = 1'b1; supply_ok = 1'b1; mic_if_en = 1'b0;
    wr(2'd1, 8'h05);
    rd(2'd0, d);
    js_raw = 1'b1;
    step(4); check("R2 not yet at L+2", {7'd0, irq}, 8'h00);
    step(1); check("R2 change at L+3", {7'd0, irq}, 8'h01);
    rd(2'd0, d); check("R7 read status", d, 8'h13);
    check("R7 irq clears after read", {7'd0, irq}, 8'h00);

    // R2: short pulse ignored
    js_raw = 1'b0; step(2); js_raw = 1'b1;
    step(10);
    check("R2 glitch no irq", {7'd0, irq}, 8'h00);
    rd(2'd0, d); check("R2 glitch status unchanged", d, 8'h03);

    // R7: read coinciding with flag event
    hpl_raw = 1'b0;
    step(4);
    reg_rd = 1'b1; reg_addr = 2'd0;
    step(1);
    reg_rd = 1'b0;
    check("R7 coincident read data", reg_rdata, 8'h03);
    check("R7 coincident flag kept", {7'd0, irq}, 8'h01);
    rd(2'd0, d); check("R7 flag seen next read", d, 8'h11);

    // R8: control readback and unmapped address
    wr(2'd1, 8'hFF);
    rd(2'd1, d); check("R8 ctrl readback", d, 8'h07);
    rd(2'd3, d); check("R8 unmapped reads zero", d, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule